// File: doc/BRIEF.md
# Counter and Input Interrupt Collector

This block gathers interrupt requests from nine sources. Eight are the terminal-count outputs of a bank of counters, and the ninth is a single digital input line. Each source has its own enable bit. A source that is enabled and shows a rising edge latches a pending bit. The block raises one level-sensitive interrupt line for as long as any pending bit is set.

Software reaches the block through a plain address, read-strobe and write-strobe interface. A write to the control address loads the enable mask. A read from the same address returns the pending bits, not the mask. A write of any value to a second address drops every pending bit at once. There is no per-bit acknowledge.

A two-state machine tracks the interrupt line:
- `ST_QUIET`: nothing is pending.
- `ST_RAISED`: at least one bit is pending.

Transitions:
- `T_CAPTURE` moves `ST_QUIET` to `ST_RAISED` when an enabled edge arrives and no clear is written in that cycle.
- `T_FLUSH` moves `ST_RAISED` back to `ST_QUIET` on a clear write.
- `T_HOLD` keeps `ST_RAISED` in every other cycle.

Top module: `irq_enable_status_unit`

## Requirements
- R1: After reset, the enable mask is all zero, no bit is pending, `irq_o` is 0, and `bus_rdata_o` is 0.
- R2: An enabled source that goes from 0 to 1 between two clock edges sets its pending bit at the second edge. Counter n uses bit n for both enable and status (n = 0..7). The digital input uses bit 8 for both.
- R3: A rising edge on a source whose enable bit is 0 leaves its pending bit at 0.
- R4: Pending bits are set by edges only. A source held at 1 after a clear does not set its bit again until it falls and rises once more.
- R5: `irq_o` is 1 exactly when at least one pending bit is 1. It rises at the same edge as the first pending bit.
- R6: A write of any data to address `CLR_ADDR` clears all pending bits at that edge, and `irq_o` is 0 after it.
- R7: When a clear write and an enabled rising edge fall on the same edge, the clear wins and that request is lost.
- R8: A write to `CTRL_ADDR` only changes the enable mask. It clears no pending bit. A read of `CTRL_ADDR` returns the pending bits in bits 8..0, not the mask.
- R9: Read data is registered. It appears on `bus_rdata_o` one edge after the read strobe and holds until the next read. Bits above 8 read 0, and a read of any other address returns 0.
- R10: A new enable mask acts on edges from the cycle after the write. Clearing an enable bit does not remove a bit that is already pending.
- R11: A write to any address other than `CTRL_ADDR` and `CLR_ADDR` changes neither the mask nor the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_tc_i | input | NUM_CNT (8) | Terminal-count outputs of the counters |
| din0_i | input | 1 | Digital input used as the ninth source |
| bus_addr_i | input | ADDR_W (4) | Register address |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wdata_i | input | DATA_W (16) | Write data |
| bus_rdata_o | output | DATA_W (16) | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
A source edge driven before clock edge k shows up on `irq_o` right after edge k. The same holds for a clear write. A read strobe presented at edge k delivers status on `bus_rdata_o` after edge k. The bench drives every stimulus on a falling clock edge and samples on the next falling edge, which is exactly one rising edge later, so each result is checked in the first cycle it is due. Tests that check that something is ignored wait a few further cycles before a status read, so that a late or wrongly re-armed capture would show at the ports.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

    // Line tracker: QUIET while nothing is pending, RAISED otherwise.
    typedef enum logic [0:0] {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } irq_state_e;

    // Transition labels, used for readability in the next-state logic.
    typedef enum logic [1:0] {
        T_NONE    = 2'd0,
        T_CAPTURE = 2'd1,
        T_FLUSH   = 2'd2,
        T_HOLD    = 2'd3
    } irq_trans_e;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int NUM_SRC = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] rise_o
);

    logic [NUM_SRC-1:0] src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_rise
        assign rise_o[g] = src_i[g] & ~src_q[g];
    end

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode #(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h2,
    parameter logic [ADDR_W-1:0] CLR_ADDR  = 4'h3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic              mask_we_o,
    output logic              clr_o,
    output logic              stat_re_o
);

    always_comb begin
        mask_we_o = wr_i && (addr_i == CTRL_ADDR);
        clr_o     = wr_i && (addr_i == CLR_ADDR);
        stat_re_o = rd_i && (addr_i == CTRL_ADDR);
    end

endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
    parameter int NUM_SRC = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_we_i,
    input  logic [NUM_SRC-1:0] mask_d_i,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic               clr_i,
    output logic [NUM_SRC-1:0] enable_o,
    output logic [NUM_SRC-1:0] pending_o,
    output logic               hit_o
);

    logic [NUM_SRC-1:0] hit_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         enable_o <= '0;
        else if (mask_we_i) enable_o <= mask_d_i;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        assign hit_vec[g] = rise_i[g] & enable_o[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pending_o[g] <= 1'b0;
            else if (clr_i)      pending_o[g] <= 1'b0;
            else if (hit_vec[g]) pending_o[g] <= 1'b1;
        end
    end

    assign hit_o = |hit_vec;

endmodule

// File: rtl/irq_enable_status_unit.sv
module irq_enable_status_unit
    import irq_unit_pkg::*;
#(
    parameter int                NUM_CNT   = 8,
    parameter int                ADDR_W    = 4,
    parameter int                DATA_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h2,
    parameter logic [ADDR_W-1:0] CLR_ADDR  = 4'h3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] cnt_tc_i,
    input  logic               din0_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o
);

    localparam int NUM_SRC = NUM_CNT + 1;
    localparam int PAD_W   = DATA_W - NUM_SRC;

    logic [NUM_SRC-1:0] src_vec;
    logic [NUM_SRC-1:0] rise_vec;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] pending_q;
    logic               mask_we;
    logic               clr_hit;
    logic               stat_re;
    logic               any_hit;
    irq_state_e         state_q, state_d;
    irq_trans_e         trans;

    // The digital input sits directly above the counter sources.
    assign src_vec = {din0_i, cnt_tc_i};

    irq_edge_detect #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_vec),
        .rise_o (rise_vec)
    );

    irq_reg_decode #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .CLR_ADDR  (CLR_ADDR)
    ) u_dec (
        .addr_i    (bus_addr_i),
        .wr_i      (bus_wr_i),
        .rd_i      (bus_rd_i),
        .mask_we_o (mask_we),
        .clr_o     (clr_hit),
        .stat_re_o (stat_re)
    );

    irq_pending_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we_i (mask_we),
        .mask_d_i  (bus_wdata_i[NUM_SRC-1:0]),
        .rise_i    (rise_vec),
        .clr_i     (clr_hit),
        .enable_o  (enable_q),
        .pending_o (pending_q),
        .hit_o     (any_hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // Next state; a clear in the same cycle as a capture wins.
    always_comb begin
        state_d = state_q;
        trans   = T_NONE;
        unique case (state_q)
            ST_QUIET: begin
                if (any_hit && !clr_hit) begin
                    state_d = ST_RAISED;
                    trans   = T_CAPTURE;
                end
            end
            ST_RAISED: begin
                if (clr_hit) begin
                    state_d = ST_QUIET;
                    trans   = T_FLUSH;
                end else begin
                    trans   = T_HOLD;
                end
            end
            default: state_d = ST_QUIET;
        endcase
    end

    // Output process
    always_comb begin
        irq_o = (state_q == ST_RAISED);
    end

    // Registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        bus_rdata_o <= '0;
        else if (bus_rd_i) bus_rdata_o <= stat_re ? {{PAD_W{1'b0}}, pending_q} : '0;
    end

endmodule

// File: rtl/irq_unit_checker.sv
module irq_unit_checker #(
    parameter int                NUM_SRC  = 9,
    parameter int                ADDR_W   = 4,
    parameter int                DATA_W   = 16,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 4'h3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic [NUM_SRC-1:0] enable_i,
    input logic [NUM_SRC-1:0] pending_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic               wr_i,
    input logic [DATA_W-1:0]  rdata_i,
    input logic               irq_i
);

    logic clr_w;
    assign clr_w = wr_i && (addr_i == CLR_ADDR);

    p_line_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i == (|pending_i));

    p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> (pending_i == '0 && !irq_i));

    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_i[DATA_W-1:NUM_SRC] == '0);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (enable_i[g] && $rose(src_i[g]) && !clr_w) |=> pending_i[g]);

        p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!enable_i[g] && !pending_i[g]) |=> !pending_i[g] || $rose(src_i[g]) == 1'b0);

        p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_w && $rose(src_i[g])) |=> !pending_i[g]);

        p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (pending_i[g] && !clr_w) |=> pending_i[g]);
    end

endmodule

bind irq_enable_status_unit irq_unit_checker #(
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CLR_ADDR (CLR_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_vec),
    .enable_i  (enable_q),
    .pending_i (pending_q),
    .addr_i    (bus_addr_i),
    .wr_i      (bus_wr_i),
    .rdata_i   (bus_rdata_o),
    .irq_i     (irq_o)
);

// File: tb/irq_enable_status_unit_test.sv
`timescale 1ns/1ps
module irq_enable_status_unit_test;

    localparam logic [3:0] A_CTRL = 4'h2;
    localparam logic [3:0] A_CLR  = 4'h3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  src = '0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_enable_status_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_tc_i    (src[7:0]),
        .din0_i      (src[8]),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic read_stat(input logic [3:0] a, output logic [15:0] v);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic pulse(input int idx);
        src[idx] = 1'b1;
        @(negedge clk);
        src[idx] = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R1 irq", {15'd0, irq}, 16'h0000);
        check("R1 rdata", rdata, 16'h0000);
        pulse(4);
        read_stat(A_CTRL, v);
        check("R1 mask zero", v, 16'h0000);
    endtask

    task automatic t_each_source;
        logic [15:0] v;
        bus_write(A_CTRL, 16'h01FF);
        for (int i = 0; i < 9; i++) begin
            src[i] = 1'b1;
            @(negedge clk);
            check("R5 irq with bit", {15'd0, irq}, 16'h0001);
            src[i] = 1'b0;
            read_stat(A_CTRL, v);
            check("R2 bit position", v, 16'(1 << i));
            bus_write(A_CLR, 16'hA5A5);
            check("R6 irq after clear", {15'd0, irq}, 16'h0000);
        end
    endtask

    task automatic t_masked;
        logic [15:0] v;
        bus_write(A_CTRL, 16'h0100);
        pulse(0); pulse(7);
        idle(2);
        read_stat(A_CTRL, v);
        check("R3 masked sources", v, 16'h0000);
        pulse(8);
        read_stat(A_CTRL, v);
        check("R3 enabled din0", v, 16'h0100);
        bus_write(A_CLR, 16'h0000);
    endtask

    task automatic t_level_hold;
        logic [15:0] v;
        bus_write(A_CTRL, 16'h01FF);
        src[3] = 1'b1;
        @(negedge clk);
        bus_write(A_CLR, 16'h0001);
        idle(3);
        read_stat(A_CTRL, v);
        check("R4 no re-set while held", v, 16'h0000);
        check("R4 irq low", {15'd0, irq}, 16'h0000);
        src[3] = 1'b0;
        @(negedge clk);
        pulse(3);
        read_stat(A_CTRL, v);
        check("R4 new edge sets", v, 16'h0008);
        bus_write(A_CLR, 16'h0000);
    endtask

    task automatic t_collision;
        logic [15:0] v;
        bus_write(A_CTRL, 16'h01FF);
        pulse(2);
        check("R7 pre irq", {15'd0, irq}, 16'h0001);
        addr = A_CLR; wdata = 16'h1234; wr = 1'b1; src[5] = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        check("R7 irq after collide", {15'd0, irq}, 16'h0000);
        idle(2);
        read_stat(A_CTRL, v);
        check("R7 request lost", v, 16'h0000);
        src[5] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_shared_addr;
        logic [15:0] v;
        bus_write(A_CTRL, 16'h01FF);
        pulse(1);
        bus_write(A_CTRL, 16'hFFFF);
        check("R8 ctrl write keeps irq", {15'd0, irq}, 16'h0001);
        read_stat(A_CTRL, v);
        check("R8 read gives status not mask", v, 16'h0002);
        read_stat(4'h7, v);
        check("R9 other address reads zero", v, 16'h0000);
        idle(2);
        check("R9 read data held", rdata, 16'h0000);
        bus_write(A_CLR, 16'h0000);
    endtask

    task automatic t_enable_timing;
        logic [15:0] v;
        bus_write(A_CTRL, 16'h0000);
        addr = A_CTRL; wdata = 16'h0001; wr = 1'b1; src[0] = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        check("R10 same-cycle enable ignored", {15'd0, irq}, 16'h0000);
        src[0] = 1'b0;
        @(negedge clk);
        pulse(0);
        check("R10 later edge sets", {15'd0, irq}, 16'h0001);
        bus_write(A_CTRL, 16'h0000);
        read_stat(A_CTRL, v);
        check("R10 disable keeps pending", v, 16'h0001);
        bus_write(A_CLR, 16'h0000);
    endtask

    task automatic t_stray;
        logic [15:0] v;
        bus_write(A_CTRL, 16'h0010);
        pulse(4);
        bus_write(4'h5, 16'hFFFF);
        bus_write(4'h0, 16'h0000);
        read_stat(A_CTRL, v);
        check("R11 stray write keeps pending", v, 16'h0010);
        bus_write(A_CLR, 16'h0000);
        pulse(4); pulse(6);
        read_stat(A_CTRL, v);
        check("R11 mask unchanged", v, 16'h0010);
        bus_write(A_CLR, 16'h0000);
    endtask

    task automatic t_multi;
        logic [15:0] v;
        bus_write(A_CTRL, 16'h01FF);
        src = 9'h181;
        @(negedge clk);
        src = '0;
        check("R5 irq multi", {15'd0, irq}, 16'h0001);
        read_stat(A_CTRL, v);
        check("R2 multi bits", v, 16'h0181);
        bus_write(A_CLR, 16'hFFFF);
        read_stat(A_CTRL, v);
        check("R6 all cleared", v, 16'h0000);
    endtask

    initial begin
        idle(3);
        @(negedge clk);
        check("R1 irq in reset", {15'd0, irq}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_each_source();
        t_masked();
        t_level_hold();
        t_collision();
        t_shared_addr();
        t_enable_timing();
        t_stray();
        t_multi();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule